// File: doc/BRIEF.md
# Dual-Enable Nibble Static Memory

This block is a 256-word store of 4-bit words. It has one 8-bit address, a 4-bit write-data port and a separate 4-bit read-data port. Two chip selects of opposite polarity must both be true before the block responds. When they are, a mute input and a read/write select choose one of four behaviours: read, write with the written data echoed on the output, write with a silent output, or a silent read.

The output models a three-state pin as a data value plus a drive flag. The flag is high only in the read mode and the echoed-write mode. When the flag is low, the data value is forced to zero. A write lands in the addressed word on the rising clock edge in which the write conditions hold. Reads are combinational from the address, so a word written in one cycle can be read in the next.

The block sits on a plain address/data bus and answers in the same cycle. There is no handshake and no back-pressure: every selected cycle is accepted. Memory contents are never cleared, and no write is committed while reset is asserted.

Top module: `nibble_store`

## Requirements
- R1: While `cs_n` is 1, `dout_en` is 0 and no word is written, whatever the other inputs are.
- R2: While `cs` is 0, `dout_en` is 0 and no word is written, whatever the other inputs are.
- R3: When the block is selected (`cs_n`=0, `cs`=1) and `out_mute` is 1, `dout_en` is 0. If `read_sel`=0 in this state, the write to `addr` is still committed.
- R4: When the block is selected, `out_mute`=0 and `read_sel`=1, `dout_en` is 1 and `dout` equals the word stored at `addr` in the same cycle.
- R5: When the block is selected, `out_mute`=0 and `read_sel`=0, `dout_en` is 1, `dout` equals `din`, and `din` is written to `addr`.
- R6: Stored words keep their values across any number of deselected cycles.
- R7: A write is committed on the rising clock edge. A read of the same address in the next cycle returns the new word.
- R8: No write is committed while `rst_n` is 0, and reset does not clear the stored words.
- R9: Whenever `dout_en` is 0, `dout` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes commit on its rising edge |
| rst_n | input | 1 | Active-low reset; blocks writes while low |
| cs_n | input | 1 | Active-low chip select |
| cs | input | 1 | Active-high chip select |
| out_mute | input | 1 | Active-high output disable |
| read_sel | input | 1 | 1 = read, 0 = write |
| addr | input | 8 | Word address |
| din | input | 4 | Write data |
| dout | output | 4 | Read or echoed data; 0 when not driven |
| dout_en | output | 1 | Output drive flag (0 = high impedance) |

## Verification
The write-then-read property assumes that an address and its data stay known for one cycle after a write. The bench meets this by changing inputs only on falling edges and holding them for a whole cycle. The checks also assume that the bench never reads a word it has not first written: contents are undefined after power-up, and the stimulus writes every address before it reads any of them. Mode inputs are always driven to 0 or 1, so the decode never sees unknown selects.

// File: rtl/nibble_store_pkg.sv
package nibble_store_pkg;

  // Chip-level behaviour chosen by the select, mute and direction pins
  typedef enum logic [2:0] {
    MODE_DESEL    = 3'd0,
    MODE_MUTE_RD  = 3'd1,
    MODE_MUTE_WR  = 3'd2,
    MODE_READ     = 3'd3,
    MODE_WRITE_FT = 3'd4
  } ns_mode_e;

  function automatic logic mode_writes(ns_mode_e m);
    return (m == MODE_MUTE_WR) || (m == MODE_WRITE_FT);
  endfunction

  function automatic logic mode_drives(ns_mode_e m);
    return (m == MODE_READ) || (m == MODE_WRITE_FT);
  endfunction

endpackage

// File: rtl/nibble_store_decode.sv
module nibble_store_decode
  import nibble_store_pkg::*;
(
  input  logic     cs_n,
  input  logic     cs,
  input  logic     out_mute,
  input  logic     read_sel,
  output ns_mode_e mode
);

  logic selected;
  assign selected = ~cs_n & cs;

  always_comb begin
    if (!selected)          mode = MODE_DESEL;
    else if (out_mute)      mode = read_sel ? MODE_MUTE_RD : MODE_MUTE_WR;
    else                    mode = read_sel ? MODE_READ    : MODE_WRITE_FT;
  end

endmodule

// File: rtl/nibble_store_array.sv
module nibble_store_array #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  // Contents are intentionally not reset
  always_ff @(posedge clk) begin
    if (wr_en) cells[addr] <= wr_data;
  end

  assign rd_data = cells[addr];

endmodule

// File: rtl/nibble_store_outsel.sv
module nibble_store_outsel
  import nibble_store_pkg::*;
#(
  parameter int DATA_W = 4
) (
  input  ns_mode_e          mode,
  input  logic [DATA_W-1:0] rd_data,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);

  always_comb begin
    dout_en = mode_drives(mode);
    unique case (mode)
      MODE_READ:     dout = rd_data;
      MODE_WRITE_FT: dout = wr_data;
      default:       dout = '0;
    endcase
  end

endmodule

// File: rtl/nibble_store.sv
module nibble_store
  import nibble_store_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              cs,
  input  logic              out_mute,
  input  logic              read_sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);

  ns_mode_e          mode;
  logic              commit;
  logic [DATA_W-1:0] rd_data;

  nibble_store_decode u_decode (
    .cs_n     (cs_n),
    .cs       (cs),
    .out_mute (out_mute),
    .read_sel (read_sel),
    .mode     (mode)
  );

  assign commit = rst_n & mode_writes(mode);

  nibble_store_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk     (clk),
    .wr_en   (commit),
    .addr    (addr),
    .wr_data (din),
    .rd_data (rd_data)
  );

  nibble_store_outsel #(.DATA_W(DATA_W)) u_outsel (
    .mode    (mode),
    .rd_data (rd_data),
    .wr_data (din),
    .dout    (dout),
    .dout_en (dout_en)
  );

endmodule

// File: rtl/nibble_store_chk.sv
module nibble_store_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              cs,
  input logic              out_mute,
  input logic              read_sel,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] din,
  input logic [DATA_W-1:0] dout,
  input logic              dout_en
);

  logic sel_ok;
  logic wr_cond;
  logic rd_cond;
  assign sel_ok  = ~cs_n & cs;
  assign wr_cond = rst_n & sel_ok & ~read_sel;
  assign rd_cond = sel_ok & ~out_mute & read_sel;

  // R1
  lo_sel_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !dout_en);

  // R2
  hi_sel_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |-> !dout_en);

  // R3
  mute_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_ok && out_mute) |-> !dout_en);

  // R4
  read_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cond |-> dout_en);

  // R5
  echo_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_ok && !out_mute && !read_sel) |-> (dout_en && dout == din));

  // R7
  write_then_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cond && $past(wr_cond) && addr == $past(addr)) |-> dout == $past(din));

  // R9
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_en |-> dout == '0);

endmodule

bind nibble_store nibble_store_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs_n     (cs_n),
  .cs       (cs),
  .out_mute (out_mute),
  .read_sel (read_sel),
  .addr     (addr),
  .din      (din),
  .dout     (dout),
  .dout_en  (dout_en)
);

// File: tb/nibble_store_tb_top.sv
`timescale 1ns/1ps
module nibble_store_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic       cs = 1'b0;
  logic       out_mute = 1'b0;
  logic       read_sel = 1'b1;
  logic [7:0] addr = '0;
  logic [3:0] din = '0;
  logic [3:0] dout;
  logic       dout_en;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [3:0] ref_mem [256];
  logic       exp_en_q  [$];
  logic [3:0] exp_dat_q [$];
  string      exp_tag_q [$];

  always #5 clk = ~clk;

  nibble_store dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cs(cs), .out_mute(out_mute),
    .read_sel(read_sel), .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
  );

  // Driver: one bus cycle, expectation derived from the requirements
  task automatic step(input logic r, input logic n, input logic h,
                      input logic m, input logic rs, input logic [7:0] a,
                      input logic [3:0] d, input string tag);
    logic sel, en;
    logic [3:0] ed;
    @(negedge clk);
    rst_n = r; cs_n = n; cs = h; out_mute = m; read_sel = rs; addr = a; din = d;
    sel = !n && h;
    en  = sel && !m;
    ed  = !en ? 4'h0 : (rs ? ref_mem[a] : d);
    exp_en_q.push_back(en);
    exp_dat_q.push_back(ed);
    exp_tag_q.push_back(tag);
    if (r && sel && !rs) ref_mem[a] = d;
  endtask

  // Monitor: compare well before the next rising edge
  initial begin
    forever begin
      @(negedge clk);
      #3;
      while (exp_en_q.size() > 0) begin
        logic e_en;
        logic [3:0] e_d;
        string t;
        e_en = exp_en_q.pop_front();
        e_d  = exp_dat_q.pop_front();
        t    = exp_tag_q.pop_front();
        checks++;
        if (dout_en !== e_en || dout !== e_d) begin
          fails++;
          $display("FAIL %s: got en=%0b dout=%h, expected en=%0b dout=%h",
                   t, dout_en, dout, e_en, e_d);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic logic [3:0] pat(int a);
    return 4'((a ^ (a >> 4) ^ 5) & 15);
  endfunction

  initial begin
    // Reset state, deselected: R9
    step(0, 1, 0, 0, 1, 8'h00, 4'h0, "R9");
    step(1, 1, 0, 0, 1, 8'h00, 4'h0, "R9");
    // Fill all words, half muted (R3), half echoed (R5)
    for (int i = 0; i < 256; i++) begin
      if (i[0]) step(1, 0, 1, 1, 0, 8'(i), pat(i), "R3");
      else      step(1, 0, 1, 0, 0, 8'(i), pat(i), "R5");
    end
    // Read back everything: R4, R3
    for (int i = 0; i < 256; i++) step(1, 0, 1, 0, 1, 8'(i), 4'h0, "R4");
    // Deselected writes: R1, R2, then retention R6
    step(1, 1, 1, 0, 0, 8'd10, ~pat(10), "R1");
    step(1, 1, 0, 1, 0, 8'd10, ~pat(10), "R1");
    step(1, 0, 0, 0, 0, 8'd10, ~pat(10), "R2");
    step(1, 1, 0, 0, 1, 8'd10, 4'h0, "R6");
    step(1, 1, 0, 0, 1, 8'd10, 4'h0, "R6");
    step(1, 0, 1, 0, 1, 8'd10, 4'h0, "R6");
    // Muted read: R3
    step(1, 0, 1, 1, 1, 8'd20, 4'h0, "R3");
    // Back-to-back write then read: R7
    step(1, 0, 1, 0, 0, 8'd20, 4'h9, "R7");
    step(1, 0, 1, 0, 1, 8'd20, 4'h0, "R7");
    step(1, 0, 1, 1, 0, 8'd21, 4'hE, "R7");
    step(1, 0, 1, 0, 1, 8'd21, 4'h0, "R7");
    // Write attempt under reset: echo still shown, no commit, no clear (R8)
    step(0, 0, 1, 0, 0, 8'd5, ~pat(5), "R8");
    step(0, 1, 0, 0, 1, 8'd5, 4'h0, "R8");
    step(1, 0, 1, 0, 1, 8'd5, 4'h0, "R8");
    step(1, 0, 1, 0, 1, 8'd20, 4'h0, "R8");
    step(1, 1, 0, 0, 1, 8'd0, 4'h0, "R9");
    @(negedge clk);
    #5;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule